// File: doc/BRIEF.md
# Cold and warm reset sequencer

This block orders the resets of a processor subsystem. A cold request can come from any of several sources, such as fabric configuration, fabric logic or internal modules. It clamps every module reset and the clock-manager reset. The clock-manager reset is released after a fixed hold time. After a further settling time, the common release sequence starts.

A warm request can come from internal sources or from the external active-low reset button. It first raises a pending-reset request towards the programmable fabric and a safe-mode request towards the clock manager. When both acknowledges are present, the module resets are clamped. The external reset pin is then pulled low for a programmable number of cycles. When that count is zero, the stretch is skipped and release waits for the button to be let go.

Both kinds of reset end in the same ordered release, with a fixed gap between steps:
1. interconnect
2. miscellaneous modules
3. core clock gate
4. cores
5. core-cluster resets (watchdog, snoop control, core peripherals, L2)
6. peripherals

A one-cycle done pulse marks the last step. Power-on reset clamps everything asynchronously. Request inputs are sampled on the sequencer clock.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low, all module resets, `clkmgr_rst_n` and `core_rst_n` are low, `core_clkoff` is 1, `fab_req_n` is 1, and `safe_req`, `pin_pull_low` and `seq_done` are 0. Release of `por_n` behaves as a cold request.
- R2: A cold request sampled on edge E holds all module resets low. It releases `clkmgr_rst_n` on edge E+COLD_HOLD (default 32).
- R3: The release sequence of a cold reset begins on edge E+COLD_HOLD+COLD_SETTLE (default 128). The first release happens STEP_GAP cycles later, on edge E+136 by default.
- R4: The release steps, each STEP_GAP cycles (default 8) after the previous, are taken in this order:
  1. `noc_rst_n`
  2. `misc_rst_n`
  3. `core_clkoff` falls
  4. `core_rst_n[0]`
  5. all four `cluster_rst_n` bits
  6. `periph_rst_n`

  `seq_done` is high for exactly the cycle after the edge that releases `periph_rst_n`.
- R5: A warm request in the idle state drives `fab_req_n` low and `safe_req` high. Module resets stay released until `fab_ack_n` is low and `safe_ack` is high on the same edge.
- R6: On the edge that sees both acknowledges, all module resets go low. `pin_pull_low` is then high for exactly `pin_cnt` cycles. `seq_done` appears `pin_cnt` + 1 + 6·STEP_GAP cycles after that edge.
- R7: With `pin_cnt` = 0 there is no stretch. The release sequence begins on the third edge after `ext_warm_n` returns high, so it starts at whichever is later: the acknowledges or the button release.
- R8: `fab_req_n` returns high and `safe_req` low on the edge that starts the release sequence, and not before.
- R9: `core_rst_n[1]` follows `core_rst_n[0]` only while `cpu1_hold` is 0. Clearing `cpu1_hold` after the sequence releases it at once.
- R10: A cold request at any point aborts the current sequence. On the next cycle the pin pull, safe-mode request and fabric request are dropped and `clkmgr_rst_n` is low. The cold timing of R2 to R4 then restarts.
- R11: Warm requests during a cold sequence are ignored: `safe_req` stays 0 and the cold timing is unchanged.
- R12: `ext_warm_n` held low for two or more cycles while idle starts a warm sequence, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cold_src | input | N_COLD | Cold reset requests, active high |
| warm_src | input | N_WARM | Internal warm reset requests, active high |
| ext_warm_n | input | 1 | External reset button/pin level, active low |
| pin_cnt | input | PIN_W | Pin stretch length in cycles; 0 skips it |
| fab_ack_n | input | 1 | Fabric pending-reset acknowledge, active low |
| safe_ack | input | 1 | Clock-manager safe-mode acknowledge |
| cpu1_hold | input | 1 | Software hold of the secondary core |
| pin_pull_low | output | 1 | Drive the external reset pin low |
| fab_req_n | output | 1 | Pending-reset request to fabric, active low |
| safe_req | output | 1 | Safe-mode request to clock manager |
| clkmgr_rst_n | output | 1 | Clock-manager cold reset, active low |
| noc_rst_n | output | 1 | Interconnect reset, active low |
| misc_rst_n | output | 1 | Miscellaneous module reset, active low |
| core_clkoff | output | 1 | Core clock gate, 1 = clock off |
| core_rst_n | output | 2 | Core resets, bit 0 primary, bit 1 secondary |
| cluster_rst_n | output | 4 | Watchdog, snoop control, core peripheral, L2 resets |
| periph_rst_n | output | 1 | Peripheral resets, active low |
| seq_done | output | 1 | One-cycle pulse at the last release |

## Verification
A wrong state or a wrong step counter shows first as a reset edge on the wrong cycle. Every release is timed against the request edge, so a counter that is off by one appears as a one-cycle shift within the same sequence. A missing or reordered step breaks the release order on the edge where it happens. A handshake state entered too early drops a module reset before both acknowledges are present. A stuck pin-stretch state shows as a wrong number of cycles with `pin_pull_low` high. A lost cold abort leaves `clkmgr_rst_n` high on the cycle after the request.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int COLD_HOLD   = 32,
  parameter int COLD_SETTLE = 96,
  parameter int STEP_GAP    = 8,
  parameter int N_COLD      = 4,
  parameter int N_WARM      = 2,
  parameter int PIN_W       = 9
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [N_COLD-1:0] cold_src,
  input  logic [N_WARM-1:0] warm_src,
  input  logic              ext_warm_n,
  input  logic [PIN_W-1:0]  pin_cnt,
  input  logic              fab_ack_n,
  input  logic              safe_ack,
  input  logic              cpu1_hold,
  output logic              pin_pull_low,
  output logic              fab_req_n,
  output logic              safe_req,
  output logic              clkmgr_rst_n,
  output logic              noc_rst_n,
  output logic              misc_rst_n,
  output logic              core_clkoff,
  output logic [1:0]        core_rst_n,
  output logic [3:0]        cluster_rst_n,
  output logic              periph_rst_n,
  output logic              seq_done
);
  localparam int PIN_MAX = (1 << PIN_W) - 1;
  localparam int M1      = (COLD_HOLD > COLD_SETTLE) ? COLD_HOLD : COLD_SETTLE;
  localparam int M2      = (M1 > STEP_GAP) ? M1 : STEP_GAP;
  localparam int MAXC    = (M2 > PIN_MAX) ? M2 : PIN_MAX;
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam int N_STEP  = 6;

  typedef enum logic [2:0] {
    S_RUN, S_CHOLD, S_CSETTLE, S_WHS, S_WPIN, S_WREL, S_REL
  } st_e;

  st_e               st;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [2:0]        stage;
  logic [N_STEP-1:0] rel;
  logic              clk_rel, hs_q, pin_q, done_q;
  logic [1:0]        ext_sync;
  logic              ext_s, cold_hit, warm_hit;

  assign cnt_nx   = cnt + 1'b1;
  assign ext_s    = ext_sync[1];
  assign cold_hit = |cold_src;
  assign warm_hit = (|warm_src) || !ext_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= S_CHOLD;
      cnt      <= '0;
      stage    <= '0;
      rel      <= '0;
      clk_rel  <= 1'b0;
      hs_q     <= 1'b0;
      pin_q    <= 1'b0;
      done_q   <= 1'b0;
      ext_sync <= 2'b11;
    end else begin
      ext_sync <= {ext_sync[0], ext_warm_n};
      done_q   <= 1'b0;
      if (cold_hit) begin
        st      <= S_CHOLD;
        cnt     <= '0;
        stage   <= '0;
        rel     <= '0;
        clk_rel <= 1'b0;
        hs_q    <= 1'b0;
        pin_q   <= 1'b0;
      end else begin
        case (st)
          S_CHOLD:
            if (cnt_nx == CNT_W'(COLD_HOLD)) begin
              clk_rel <= 1'b1;
              cnt     <= '0;
              st      <= S_CSETTLE;
            end else cnt <= cnt_nx;
          S_CSETTLE:
            if (cnt_nx == CNT_W'(COLD_SETTLE)) begin
              cnt   <= '0;
              stage <= '0;
              st    <= S_REL;
            end else cnt <= cnt_nx;
          S_RUN:
            if (warm_hit) begin
              hs_q <= 1'b1;
              st   <= S_WHS;
            end
          S_WHS:
            if (!fab_ack_n && safe_ack) begin
              rel <= '0;
              cnt <= '0;
              if (pin_cnt != '0) begin
                pin_q <= 1'b1;
                st    <= S_WPIN;
              end else st <= S_WREL;
            end
          S_WPIN:
            if (cnt_nx == CNT_W'(pin_cnt)) begin
              pin_q <= 1'b0;
              cnt   <= '0;
              st    <= S_WREL;
            end else cnt <= cnt_nx;
          S_WREL:
            if (ext_s) begin
              hs_q  <= 1'b0;
              cnt   <= '0;
              stage <= '0;
              st    <= S_REL;
            end
          S_REL:
            if (cnt_nx == CNT_W'(STEP_GAP)) begin
              cnt   <= '0;
              rel   <= rel | (N_STEP'(1) << stage);
              stage <= stage + 3'd1;
              if (stage == 3'(N_STEP - 1)) begin
                done_q <= 1'b1;
                st     <= S_RUN;
              end
            end else cnt <= cnt_nx;
          default: st <= S_CHOLD;
        endcase
      end
    end
  end

  assign clkmgr_rst_n  = clk_rel;
  assign noc_rst_n     = rel[0];
  assign misc_rst_n    = rel[1];
  assign core_clkoff   = !rel[2];
  assign core_rst_n    = {rel[3] & !cpu1_hold, rel[3]};
  assign cluster_rst_n = {4{rel[4]}};
  assign periph_rst_n  = rel[5];
  assign fab_req_n     = !hs_q;
  assign safe_req      = hs_q;
  assign pin_pull_low  = pin_q;
  assign seq_done      = done_q;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int N_COLD = 4,
  parameter int N_WARM = 2,
  parameter int PIN_W  = 9
) (
  input logic              clk,
  input logic              por_n,
  input logic [N_COLD-1:0] cold_src,
  input logic [N_WARM-1:0] warm_src,
  input logic              ext_warm_n,
  input logic [PIN_W-1:0]  pin_cnt,
  input logic              fab_ack_n,
  input logic              safe_ack,
  input logic              cpu1_hold,
  input logic              pin_pull_low,
  input logic              fab_req_n,
  input logic              safe_req,
  input logic              clkmgr_rst_n,
  input logic              noc_rst_n,
  input logic              misc_rst_n,
  input logic              core_clkoff,
  input logic [1:0]        core_rst_n,
  input logic [3:0]        cluster_rst_n,
  input logic              periph_rst_n,
  input logic              seq_done
);
  p_cold_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    !clkmgr_rst_n |-> (!noc_rst_n && !misc_rst_n && core_clkoff && core_rst_n == 2'b00
                       && cluster_rst_n == 4'b0 && !periph_rst_n));

  p_order_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!misc_rst_n || noc_rst_n) && (core_clkoff || misc_rst_n) &&
    (!core_rst_n[0] || !core_clkoff) && (!core_rst_n[1] || core_rst_n[0]) &&
    (cluster_rst_n == 4'b0 || core_rst_n[0]) && (!periph_rst_n || cluster_rst_n == 4'hf));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!por_n)
    seq_done |=> !seq_done);

  p_done_last_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(periph_rst_n) |-> seq_done);

  p_warm_ack_r5: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(noc_rst_n) && !$past(|cold_src)) |-> ($past(safe_ack) && !$past(fab_ack_n)));

  p_pin_r6: assert property (@(posedge clk) disable iff (!por_n)
    pin_pull_low |-> (safe_req && !fab_req_n && !noc_rst_n));

  p_hs_release_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(noc_rst_n) |-> (!safe_req && fab_req_n));

  p_cold_abort_r10: assert property (@(posedge clk) disable iff (!por_n)
    $past(|cold_src) |-> (!clkmgr_rst_n && !pin_pull_low && !safe_req && fab_req_n));

  p_warm_ignored_r11: assert property (@(posedge clk) disable iff (!por_n)
    !clkmgr_rst_n |-> !safe_req);
endmodule

bind rst_sequencer rst_sequencer_chk #(.N_COLD(N_COLD), .N_WARM(N_WARM), .PIN_W(PIN_W)) chk_i (.*);

// File: tb/rst_sequencer_tb_top.sv
module rst_sequencer_tb_top;
  localparam int HOLD = 32, SETTLE = 96, GAP = 8, NC = 4, NW = 2, PW = 9;
  localparam int T0 = HOLD + SETTLE;
  localparam int TLAST = T0 + 6 * GAP;
  // warm scenarios: source (0/1 internal, 2 pin), pin_cnt, ack delay, expected done index
  localparam int WT [4][4] = '{'{0, 0, 3, 49}, '{1, 5, 0, 54}, '{2, 3, 2, 52}, '{0, 16, 7, 65}};

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [NC-1:0] cold_src = '0;
  logic [NW-1:0] warm_src = '0;
  logic ext_warm_n = 1'b1;
  logic [PW-1:0] pin_cnt = '0;
  logic fab_ack_n = 1'b1, safe_ack = 1'b0, cpu1_hold = 1'b1;
  logic pin_pull_low, fab_req_n, safe_req, clkmgr_rst_n, noc_rst_n, misc_rst_n, core_clkoff;
  logic [1:0] core_rst_n;
  logic [3:0] cluster_rst_n;
  logic periph_rst_n, seq_done;
  int checks = 0, failures = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  rst_sequencer #(.COLD_HOLD(HOLD), .COLD_SETTLE(SETTLE), .STEP_GAP(GAP),
                  .N_COLD(NC), .N_WARM(NW), .PIN_W(PW)) dut_i (
    .clk(clk), .por_n(por_n), .cold_src(cold_src), .warm_src(warm_src),
    .ext_warm_n(ext_warm_n), .pin_cnt(pin_cnt), .fab_ack_n(fab_ack_n),
    .safe_ack(safe_ack), .cpu1_hold(cpu1_hold), .pin_pull_low(pin_pull_low),
    .fab_req_n(fab_req_n), .safe_req(safe_req), .clkmgr_rst_n(clkmgr_rst_n),
    .noc_rst_n(noc_rst_n), .misc_rst_n(misc_rst_n), .core_clkoff(core_clkoff),
    .core_rst_n(core_rst_n), .cluster_rst_n(cluster_rst_n),
    .periph_rst_n(periph_rst_n), .seq_done(seq_done));

  function automatic logic [14:0] obs();
    return {clkmgr_rst_n, noc_rst_n, misc_rst_n, core_clkoff, core_rst_n, cluster_rst_n,
            periph_rst_n, seq_done, pin_pull_low, fab_req_n, safe_req};
  endfunction

  function automatic logic [14:0] exp_cold(int i);
    logic c0;
    c0 = (i >= T0 + 4 * GAP);
    return {i >= HOLD, i >= T0 + GAP, i >= T0 + 2 * GAP, i < T0 + 3 * GAP,
            c0 && !cpu1_hold, c0, {4{i >= T0 + 5 * GAP}}, i >= TLAST, i == TLAST,
            1'b0, 1'b1, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // R2 R3 R4 R11: index 0 is the negedge just after the cold edge
  task automatic cold_walk(input int warm_at);
    for (int i = 0; i <= TLAST + 1; i++) begin
      warm_src[0] = (i == warm_at);
      chk((warm_at >= 0) ? "R11 cold timeline with warm pulse" : "R2/R3/R4 cold timeline",
          32'(obs()), 32'(exp_cold(i)));
      @(negedge clk);
    end
    warm_src = '0;
  endtask

  task automatic pulse_cold(input int k);
    cold_src[k] = 1'b1;
    @(negedge clk);
    cold_src = '0;
  endtask

  task automatic trigger_warm(input int src);
    if (src < 2) begin
      warm_src[src] = 1'b1;
      @(negedge clk);
      warm_src = '0;
    end else begin
      ext_warm_n = 1'b0;
      repeat (3) @(negedge clk);
      ext_warm_n = 1'b1;
    end
    for (int w = 0; w < 10 && fab_req_n; w++) @(negedge clk);
    chk(src == 2 ? "R12 pin starts warm" : "R5 warm request", {fab_req_n, safe_req, noc_rst_n}, 3'b011);
  endtask

  task automatic give_acks(input int ad);
    repeat (ad) @(negedge clk);
    fab_ack_n = 1'b0;
    @(negedge clk);
    chk("R5 held until both acks", noc_rst_n, 1'b1);
    safe_ack = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_warm(input int src, input int pin, input int ad, input int expd);
    int idx, pc;
    pin_cnt = PW'(pin);
    trigger_warm(src);
    give_acks(ad);
    chk("R6 clamp at ack edge", {noc_rst_n, periph_rst_n, pin_pull_low}, {2'b00, pin != 0});
    idx = 0;
    pc = 0;
    while (!seq_done && idx < 3000) begin
      if (pin_pull_low) pc++;
      if (idx == pin) chk("R8 handshake still held", {fab_req_n, safe_req}, 2'b01);
      if (idx == pin + 1) chk("R8 handshake released", {fab_req_n, safe_req}, 2'b10);
      @(negedge clk);
      idx++;
    end
    chk("R6 done index", idx, expd);
    chk("R6 stretch length", pc, pin);
    fab_ack_n = 1'b1;
    safe_ack = 1'b0;
    @(negedge clk);
    chk("R4 released after warm", {periph_rst_n, seq_done, core_rst_n[0]}, 3'b101);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 32'(obs()), 32'({1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 4'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}));
    por_n = 1'b1;
    cold_walk(-1);

    chk("R9 secondary held", core_rst_n, 2'b01);
    cpu1_hold = 1'b0;
    #1;
    chk("R9 secondary released", core_rst_n, 2'b11);

    for (int t = 0; t < 4; t++) run_warm(WT[t][0], WT[t][1], WT[t][2], WT[t][3]);

    // R7: no stretch, button still held after acks
    pin_cnt = '0;
    ext_warm_n = 1'b0;
    for (int w = 0; w < 10 && fab_req_n; w++) @(negedge clk);
    give_acks(1);
    chk("R7 clamp without stretch", {noc_rst_n, pin_pull_low}, 2'b00);
    repeat (30) @(negedge clk);
    chk("R7 waits for button", {noc_rst_n, safe_req, fab_req_n}, 3'b010);
    ext_warm_n = 1'b1;
    @(negedge clk);
    begin
      int idx = 0;
      while (!seq_done && idx < 3000) begin
        @(negedge clk);
        idx++;
      end
      chk("R7 done after release", idx, 2 + 6 * GAP);
    end
    fab_ack_n = 1'b1;
    safe_ack = 1'b0;
    @(negedge clk);

    // R10: cold during pin stretch
    pin_cnt = PW'(20);
    trigger_warm(1);
    give_acks(0);
    repeat (5) @(negedge clk);
    chk("R10 stretching before abort", pin_pull_low, 1'b1);
    fab_ack_n = 1'b1;
    safe_ack = 1'b0;
    pulse_cold(2);
    chk("R10 abort drops warm outputs", {pin_pull_low, safe_req, fab_req_n, clkmgr_rst_n}, 4'b0010);
    cold_walk(-1);

    // R11: warm pulse inside cold sequence
    pulse_cold(0);
    cold_walk(10);
    chk("R11 no warm after cold", {safe_req, fab_req_n}, 2'b01);

    finish_run();
  end
endmodule